// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Bus Master

This block is a two-wire bus master that moves data to and from a serial EEPROM holding 8 KB of byte-addressed storage. A client raises one request that names the operation, the three chip-select bits, a 13-bit start address and a byte count. The block then sequences the whole bus transaction on its own: START, the control byte, the two address bytes, the data phase, any repeated START, and STOP.

Write data is pulled from the client one byte at a time. The `wr_take` pulse marks the cycle in which `wr_data` was consumed, and the client must present the next byte before the following data slot. Read bytes are handed out with a one-cycle `rd_valid` strobe. The bus lines are open drain. The block only pulls SCL or SDA low through `scl_oe` and `sda_oe`, and it reads the SDA wire back on `sda_in`.

After any STOP that closes a write, the block withholds `req_ready` for a programmed number of cycles. This covers the memory's internal programming time. A missing acknowledge from the slave ends the transfer with a STOP and an error strobe, so the block never stalls on the bus.

Top module: `eep_page_master`

## Requirements
- R1: After reset both bus lines are released (`scl_oe`=0, `sda_oe`=0) and `req_ready`=1.
- R2: Every bus slot lasts four quarter phases of QTR_DIV clocks each. SCL is pulled low in quarters 0 and 3 and released in quarters 1 and 2, so each SCL high interval lasts 2*QTR_DIV clocks. A transmitted data bit on SDA changes only while SCL is low. The master samples SDA at the end of quarter 2.
- R3: START is SDA falling while SCL is high, and STOP is SDA rising while SCL is high. The control byte is sent MSB first as 1010, then chip[2:0], then the R/W bit, where 0 means write and 1 means read.
- R4: The 13-bit address follows the write control byte as a high byte {000, addr[12:8]} and then a low byte addr[7:0], each acknowledged by the slave.
- R5: With op=0 (single write), exactly one data byte is sent and then STOP. The count field is ignored.
- R6: With op=1 (page write), req_cnt data bytes are sent, with one `wr_take` pulse for each byte consumed.
- R7: A page write is refused when cnt=0, when cnt>32, or when addr[4:0]+cnt>32. A refusal pulses `req_rej`, produces no bus activity, and leaves the memory untouched.
- R8: With op=2 (random read), the master sends a dummy write of the control byte and address, then a repeated START, then the control byte with R/W=1. It receives one byte, answers with a NACK, and sends STOP. The byte appears on `rd_data` with `rd_valid`.
- R9: With op=3 (sequential read), req_cnt consecutive bytes are returned. The master ACKs every byte except the last, which it NACKs. A count of 0 is refused through `req_rej`.
- R10: When SDA is high in any slave acknowledge slot, the master sends STOP and pulses `nack_err` instead of `done`.
- R11: After the STOP of a write operation (op 0 or 1, completed or aborted), `req_ready` stays low for HOLD_CYC+1 cycles, counted from the cycle of the `done` or `nack_err` pulse. After a read, `req_ready` is high in that same cycle.
- R12: `done` pulses once, at the end of STOP, for each transfer that completes without error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, taken while req_ready is high |
| req_ready | output | 1 | Master idle and free to accept a request |
| req_op | input | 2 | 0 single write, 1 page write, 2 random read, 3 sequential read |
| req_chip | input | 3 | Chip-select bits placed in the control byte |
| req_addr | input | 13 | Start byte address |
| req_cnt | input | CNT_W | Byte count for page write and sequential read |
| wr_data | input | 8 | Next byte to write |
| wr_take | output | 1 | Pulse: wr_data was consumed |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | Pulse: rd_data holds a new byte |
| done | output | 1 | Pulse: transfer finished without error |
| nack_err | output | 1 | Pulse: transfer aborted on a missing acknowledge |
| req_rej | output | 1 | Pulse: request refused |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | SDA wire level |

## Verification
The bench sweeps page writes whose end lands exactly on the page boundary, and page writes one byte past it. A design that checked the page boundary wrongly would corrupt wrapped bytes or refuse a legal request. Sequential reads of several lengths check the acknowledge pattern, since a master that ACKed the last byte would leave the slave driving SDA when STOP is due. A slave that refuses a data byte and a wrong chip-select confirm that the master aborts cleanly and still applies the write hold. The hold length is measured to the cycle, which exposes an off-by-one timer or a hold wrongly applied after reads.

// File: rtl/eep_pkg.sv
package eep_pkg;

  localparam logic [3:0] DEV_TYPE = 4'b1010;

  typedef enum logic [1:0] {
    OP_WR1 = 2'd0,
    OP_WRP = 2'd1,
    OP_RD1 = 2'd2,
    OP_RDN = 2'd3
  } eep_op_e;

  typedef enum logic [2:0] {
    S_IDLE, S_START, S_TX, S_SACK, S_RX, S_MACK, S_STOP, S_HOLD
  } eep_st_e;

  typedef enum logic [2:0] {
    G_CW, G_AH, G_AL, G_WD, G_CR
  } eep_stage_e;

  function automatic logic [7:0] ctrl_byte(input logic [2:0] chip, input logic rd);
    return {DEV_TYPE, chip, rd};
  endfunction

  function automatic logic is_read(input eep_op_e op);
    return (op == OP_RD1) || (op == OP_RDN);
  endfunction

  // Request legality: page writes must stay inside one page.
  function automatic logic req_ok(input eep_op_e op, input int offs, input int cnt, input int page);
    case (op)
      OP_WRP:  return (cnt != 0) && (cnt <= page) && (offs + cnt <= page);
      OP_RDN:  return cnt != 0;
      default: return 1'b1;
    endcase
  endfunction

endpackage

// File: rtl/eep_qphase.sv
module eep_qphase #(
  parameter int QTR_DIV = 50
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       qtick,
  output logic [1:0] phase,
  output logic       slot_end
);
  localparam int DW = (QTR_DIV > 1) ? $clog2(QTR_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(QTR_DIV - 1);

  logic [DW-1:0] div_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q <= '0;
      phase <= 2'd0;
    end else if (!run) begin
      div_q <= '0;
      phase <= 2'd0;
    end else if (div_q == DIV_LAST) begin
      div_q <= '0;
      phase <= phase + 2'd1;
    end else begin
      div_q <= div_q + DW'(1);
    end
  end

  assign qtick    = run && (div_q == DIV_LAST);
  assign slot_end = qtick && (phase == 2'd3);

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run) && run && $past(qtick)) |-> (phase == $past(phase) + 2'd1));

endmodule

// File: rtl/eep_hold_timer.sv
module eep_hold_timer #(
  parameter int HOLD_CYC = 250000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic busy
);
  localparam int HW = $clog2(HOLD_CYC + 2);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (load)
      cnt_q <= HW'(HOLD_CYC);
    else if (cnt_q != '0)
      cnt_q <= cnt_q - HW'(1);
  end

  assign busy = (cnt_q != '0);

  // R11
  hold_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(busy) && !$past(load)) |-> (cnt_q == $past(cnt_q) - HW'(1)));

endmodule

// File: rtl/eep_page_master.sv
module eep_page_master
  import eep_pkg::*;
#(
  parameter int QTR_DIV    = 50,
  parameter int HOLD_CYC   = 250000,
  parameter int PAGE_BYTES = 32,
  parameter int CNT_W      = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [1:0]       req_op,
  input  logic [2:0]       req_chip,
  input  logic [12:0]      req_addr,
  input  logic [CNT_W-1:0] req_cnt,
  input  logic [7:0]       wr_data,
  output logic             wr_take,
  output logic [7:0]       rd_data,
  output logic             rd_valid,
  output logic             done,
  output logic             nack_err,
  output logic             req_rej,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  localparam int PG_W = $clog2(PAGE_BYTES);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  eep_st_e          st;
  eep_stage_e       stg;
  eep_op_e          op_q;
  logic [2:0]       chip_q;
  logic [12:0]      addr_q;
  logic [CNT_W-1:0] rem;
  logic [2:0]       bcnt;
  logic [7:0]       tx_sr;
  logic [7:0]       rx_sr;
  logic             smp_q;
  logic             err_q;
  logic [CNT_W:0]   take_n;

  // named internal events
  logic run, qtick, slot_end, smp_now, hold_busy, hold_load, last_byte, wr_op;
  logic [1:0] ph;
  eep_op_e req_op_e;

  assign req_op_e  = eep_op_e'(req_op);
  assign run       = (st != S_IDLE) && (st != S_HOLD);
  assign smp_now   = qtick && (ph == 2'd2);
  assign last_byte = (rem == ONE);
  assign wr_op     = !is_read(op_q);
  assign hold_load = (st == S_STOP) && slot_end && wr_op;
  assign req_ready = (st == S_IDLE);

  eep_qphase #(.QTR_DIV(QTR_DIV)) u_qph (
    .clk(clk), .rst_n(rst_n), .run(run),
    .qtick(qtick), .phase(ph), .slot_end(slot_end)
  );

  eep_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk(clk), .rst_n(rst_n), .load(hold_load), .busy(hold_busy)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      stg      <= G_CW;
      op_q     <= OP_WR1;
      chip_q   <= 3'd0;
      addr_q   <= '0;
      rem      <= '0;
      bcnt     <= 3'd0;
      tx_sr    <= 8'hFF;
      rx_sr    <= 8'h00;
      smp_q    <= 1'b1;
      err_q    <= 1'b0;
      take_n   <= '0;
      rd_data  <= 8'h00;
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      done     <= 1'b0;
      nack_err <= 1'b0;
      req_rej  <= 1'b0;
    end else begin
      rd_valid <= 1'b0;
      wr_take  <= 1'b0;
      done     <= 1'b0;
      nack_err <= 1'b0;
      req_rej  <= 1'b0;
      if (wr_take) take_n <= take_n + (CNT_W+1)'(1);
      if (smp_now) smp_q <= sda_in;
      case (st)
        S_IDLE: begin
          if (req_valid) begin
            if (req_ok(req_op_e, int'(req_addr[PG_W-1:0]), int'(req_cnt), PAGE_BYTES)) begin
              op_q   <= req_op_e;
              chip_q <= req_chip;
              addr_q <= req_addr;
              rem    <= (req_op_e == OP_WR1 || req_op_e == OP_RD1) ? ONE : req_cnt;
              stg    <= G_CW;
              err_q  <= 1'b0;
              take_n <= '0;
              bcnt   <= 3'd0;
              st     <= S_START;
            end else begin
              req_rej <= 1'b1;
            end
          end
        end
        S_START: begin
          if (slot_end) begin
            tx_sr <= ctrl_byte(chip_q, stg == G_CR);
            st    <= S_TX;
          end
        end
        S_TX: begin
          if (slot_end) begin
            tx_sr <= {tx_sr[6:0], 1'b1};
            bcnt  <= bcnt + 3'd1;
            if (bcnt == 3'd7) st <= S_SACK;
          end
        end
        S_SACK: begin
          if (slot_end) begin
            if (smp_q) begin
              err_q <= 1'b1;
              st    <= S_STOP;
            end else begin
              case (stg)
                G_CW: begin
                  tx_sr <= {3'b000, addr_q[12:8]};
                  stg   <= G_AH;
                  st    <= S_TX;
                end
                G_AH: begin
                  tx_sr <= addr_q[7:0];
                  stg   <= G_AL;
                  st    <= S_TX;
                end
                G_AL: begin
                  if (is_read(op_q)) begin
                    stg <= G_CR;
                    st  <= S_START;
                  end else begin
                    tx_sr   <= wr_data;
                    wr_take <= 1'b1;
                    stg     <= G_WD;
                    st      <= S_TX;
                  end
                end
                G_WD: begin
                  rem <= rem - ONE;
                  if (last_byte) begin
                    st <= S_STOP;
                  end else begin
                    tx_sr   <= wr_data;
                    wr_take <= 1'b1;
                    st      <= S_TX;
                  end
                end
                default: begin
                  st <= S_RX;
                end
              endcase
            end
          end
        end
        S_RX: begin
          if (smp_now) rx_sr <= {rx_sr[6:0], sda_in};
          if (slot_end) begin
            bcnt <= bcnt + 3'd1;
            if (bcnt == 3'd7) begin
              rd_data  <= rx_sr;
              rd_valid <= 1'b1;
              st       <= S_MACK;
            end
          end
        end
        S_MACK: begin
          if (slot_end) begin
            rem <= rem - ONE;
            st  <= last_byte ? S_STOP : S_RX;
          end
        end
        S_STOP: begin
          if (slot_end) begin
            if (err_q) nack_err <= 1'b1;
            else       done     <= 1'b1;
            st <= wr_op ? S_HOLD : S_IDLE;
          end
        end
        S_HOLD: begin
          if (!hold_busy) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  // Line drive: open drain, only pull-low enables.
  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_START: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = ph[1];
      end
      S_TX: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = !tx_sr[7];
      end
      S_SACK, S_RX: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
      end
      S_MACK: begin
        scl_oe = (ph == 2'd0) || (ph == 2'd3);
        sda_oe = !last_byte;
      end
      S_STOP: begin
        scl_oe = (ph == 2'd0);
        sda_oe = !ph[1];
      end
      default: ;
    endcase
  end

  // R2
  tx_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_TX && $past(st) == S_TX && !scl_oe && !$past(scl_oe)) |-> $stable(sda_oe));

  // R12
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, nack_err, req_rej, rd_valid}));

  // R11
  hold_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold_busy |-> !req_ready);

  // R6
  page_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_take |-> (take_n < (CNT_W+1)'(PAGE_BYTES)));

  // R8
  rd_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> is_read(op_q));

  // R7
  rej_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_rej |-> (st == S_IDLE && !scl_oe && !sda_oe));

endmodule

// File: tb/sim_eep_page_master.sv
`timescale 1ns/1ps
module sim_eep_page_master;
  localparam int QTR  = 2;
  localparam int HOLD = 300;
  localparam int CW   = 8;
  localparam logic [2:0] SCHIP = 3'b101;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [1:0]    req_op = 2'd0;
  logic [2:0]    req_chip = SCHIP;
  logic [12:0]   req_addr = '0;
  logic [CW-1:0] req_cnt = '0;
  logic [7:0]    wr_data;
  logic          wr_take, rd_valid, done, nack_err, req_rej, scl_oe, sda_oe;
  logic [7:0]    rd_data;
  logic          s_low = 1'b0;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || s_low);

  eep_page_master #(.QTR_DIV(QTR), .HOLD_CYC(HOLD), .PAGE_BYTES(32), .CNT_W(CW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_chip(req_chip), .req_addr(req_addr), .req_cnt(req_cnt),
    .wr_data(wr_data), .wr_take(wr_take), .rd_data(rd_data), .rd_valid(rd_valid),
    .done(done), .nack_err(nack_err), .req_rej(req_rej),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_line)
  );

  int errors = 0, checks = 0;
  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // write source and read sink
  logic [7:0] wbuf [0:63];
  logic [7:0] rbuf [0:63];
  int wt_n = 0, rd_n = 0, cyc = 0, bad_w = 0, n_fall = 0, hcnt = 0;
  assign wr_data = wbuf[wt_n[5:0]];

  always @(negedge clk) begin
    cyc++;
    if (rd_valid) begin rbuf[rd_n[5:0]] = rd_data; rd_n++; end
    if (wr_take) wt_n++;
    if (!req_ready) begin
      if (scl_line) hcnt++;
      else begin
        if (hcnt != 0) begin n_fall++; if (hcnt != 2*QTR) bad_w++; end
        hcnt = 0;
      end
    end else hcnt = 0;
  end

  // EEPROM slave model
  logic [7:0] mem [0:255];
  int s_ph = 0, s_bit = 0, n_start = 0, n_stop = 0, n_mack = 0, n_mnack = 0;
  logic [7:0] s_sh = 0, s_tx = 0, last_ctrl = 0, last_ahi = 0;
  logic [12:0] s_ptr = 0;
  bit ps = 1, psd = 1, s_mack = 0, s_first = 0, nack_data = 0, ackb;
  bit cs, cd;

  always @(negedge clk) begin
    cs = scl_line; cd = sda_line;
    if (cs && ps && psd && !cd) begin
      n_start++; s_ph = 1; s_bit = 0; s_low = 0;
    end else if (cs && ps && !psd && cd) begin
      n_stop++; s_ph = 0; s_low = 0;
    end else if (cs && !ps) begin
      if (s_ph != 0) begin
        if (s_bit < 8) s_sh = {s_sh[6:0], cd};
        else if (s_ph == 5 && !s_first) begin
          s_mack = !cd;
          if (s_mack) n_mack++; else n_mnack++;
        end
        s_bit++;
      end
    end else if (!cs && ps && s_ph != 0) begin
      if (s_bit == 8) begin
        if (s_ph == 5 && !s_first) s_low = 0;
        else begin
          ackb = 1;
          case (s_ph)
            1: begin
              last_ctrl = s_sh;
              if (s_sh[7:1] != {4'b1010, SCHIP}) ackb = 0;
              else if (s_sh[0]) begin s_ph = 5; s_first = 1; end
              else s_ph = 2;
            end
            2: begin s_ptr[12:8] = s_sh[4:0]; last_ahi = s_sh; s_ph = 3; end
            3: begin s_ptr[7:0] = s_sh; s_ph = 4; end
            4: begin
              if (nack_data) ackb = 0;
              else begin mem[s_ptr[7:0]] = s_sh; s_ptr[4:0] = s_ptr[4:0] + 5'd1; end
            end
            default: ;
          endcase
          s_low = ackb;
          if (!ackb) s_ph = 0;
        end
      end else if (s_bit == 9) begin
        s_bit = 0; s_low = 0;
        if (s_ph == 5) begin
          if (s_first || s_mack) begin
            s_tx = mem[s_ptr[7:0]]; s_ptr = s_ptr + 13'd1; s_first = 0; s_low = !s_tx[7];
          end else s_ph = 0;
        end
      end else if (s_ph == 5 && s_bit >= 1 && s_bit <= 7) begin
        s_low = !s_tx[7 - s_bit];
      end
    end
    ps = cs; psd = cd;
  end

  // watchdog
  initial begin
    wait (cyc > 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  int got_done, got_err, got_rej, rdy_at_end;

  task automatic run_req(input int op, input logic [2:0] chip, input int addr, input int cnt);
    got_done = 0; got_err = 0; got_rej = 0;
    wt_n = 0; rd_n = 0;
    @(negedge clk);
    req_op = op[1:0]; req_chip = chip; req_addr = addr[12:0]; req_cnt = cnt[CW-1:0];
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (req_rej) begin got_rej = 1; return; end
    while (!(done || nack_err)) @(negedge clk);
    got_done = done; got_err = nack_err; rdy_at_end = req_ready;
  endtask

  task automatic wait_ready(output int lowc);
    lowc = 0;
    while (!req_ready) begin lowc++; @(negedge clk); end
  endtask

  function automatic logic [7:0] pat(input int a);
    return 8'((a * 53 + 17) ^ (a >> 3));
  endfunction

  initial begin
    int lowc, st0, sp0, ma0, mn0, ok, a, n;
    int lens [5] = '{1, 2, 7, 32, 40};
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    for (int i = 0; i < 64; i++) wbuf[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1
    chk(scl_line && sda_line && req_ready, "R1 reset lines/ready", {scl_line, sda_line, req_ready}, 7);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // single writes then random reads
    for (int i = 0; i < 6; i++) begin
      a = 13'h1000 + i * 203;
      wbuf[0] = pat(a);
      run_req(0, SCHIP, a, 9);
      chk(got_done == 1, "R12 single write done", got_done, 1);
      chk(last_ctrl == 8'hAA, "R3 write control byte", last_ctrl, 8'hAA);
      chk(last_ahi == {3'b000, 5'(a >> 8)}, "R4 address high byte", last_ahi, a >> 8);
      chk(wt_n == 1 && mem[a & 255] == pat(a), "R5 single write data", mem[a & 255], pat(a));
      wait_ready(lowc);
      chk(lowc == HOLD + 1, "R11 write hold length", lowc, HOLD + 1);
      st0 = n_start; sp0 = n_stop; mn0 = n_mnack; ma0 = n_mack;
      run_req(2, SCHIP, a, 0);
      chk(rd_n == 1 && rbuf[0] == pat(a), "R8 random read data", rbuf[0], pat(a));
      chk(last_ctrl == 8'hAB && n_start - st0 == 2 && n_stop - sp0 == 1, "R8 repeated start framing",
          n_start - st0, 2);
      chk(n_mnack - mn0 == 1 && n_mack == ma0, "R8 master nack", n_mnack - mn0, 1);
      chk(rdy_at_end == 1, "R11 no hold after read", rdy_at_end, 1);
    end

    // page writes, including one ending exactly on the boundary
    begin
      int pa [4] = '{13'h0040, 13'h0060, 13'h008A, 13'h00A3};
      int pl [4] = '{1, 32, 22, 5};
      for (int k = 0; k < 4; k++) begin
        for (int j = 0; j < 64; j++) wbuf[j] = pat(pa[k] + j + 7);
        run_req(1, SCHIP, pa[k], pl[k]);
        chk(got_done == 1 && wt_n == pl[k], "R6 page write byte takes", wt_n, pl[k]);
        ok = 1;
        for (int j = 0; j < pl[k]; j++) if (mem[(pa[k] + j) & 255] != pat(pa[k] + j + 7)) ok = 0;
        chk(ok == 1, "R6 page write contents", ok, 1);
        wait_ready(lowc);
      end
    end

    // refusals
    begin
      int ro [4] = '{1, 1, 1, 3};
      int ra [4] = '{13'h008A, 13'h00C0, 13'h00C0, 13'h0010};
      int rc [4] = '{23, 33, 0, 0};
      for (int k = 0; k < 4; k++) begin
        st0 = n_start;
        a = mem[ra[k] & 255];
        run_req(ro[k], SCHIP, ra[k], rc[k]);
        ok = 1;
        for (int t = 0; t < 40; t++) begin
          if (!scl_line || !sda_line || !req_ready) ok = 0;
          @(negedge clk);
        end
        chk(got_rej == 1, k == 3 ? "R9 zero-length read refused" : "R7 page request refused", got_rej, 1);
        chk(ok == 1 && n_start == st0 && mem[ra[k] & 255] == a, "R7 refusal leaves bus idle", ok, 1);
      end
    end

    // sequential reads over a preset pattern
    for (int i = 0; i < 256; i++) mem[i] = 8'(i ^ 8'h5A);
    for (int k = 0; k < 5; k++) begin
      a = 13'h00E0 + k * 3;
      n = lens[k];
      ma0 = n_mack; mn0 = n_mnack;
      run_req(3, SCHIP, a, n);
      ok = (rd_n == n);
      for (int j = 0; j < n; j++) if (rbuf[j] != 8'(((a + j) & 255) ^ 8'h5A)) ok = 0;
      chk(got_done == 1 && ok == 1, "R9 sequential read data", rd_n, n);
      chk(n_mack - ma0 == n - 1 && n_mnack - mn0 == 1, "R9 ack all but last", n_mack - ma0, n - 1);
    end

    // slave refusals
    sp0 = n_stop;
    run_req(2, 3'b001, 13'h0010, 0);
    chk(got_err == 1 && got_done == 0 && n_stop - sp0 == 1, "R10 wrong chip nack", got_err, 1);
    chk(rdy_at_end == 1, "R11 read abort has no hold", rdy_at_end, 1);
    nack_data = 1;
    for (int j = 0; j < 64; j++) wbuf[j] = 8'h33;
    run_req(1, SCHIP, 13'h0100, 4);
    chk(got_err == 1 && wt_n == 1, "R10 data nack aborts", wt_n, 1);
    wait_ready(lowc);
    chk(lowc == HOLD + 1, "R11 hold after aborted write", lowc, HOLD + 1);
    nack_data = 0;

    chk(bad_w == 0 && n_fall > 100, "R2 SCL high width", bad_w, 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule